// File: doc/BRIEF.md
# Byte-Lane Synchronous RAM Port

This block is one access port of a synchronous static RAM. The data word is split into byte lanes (four lanes of nine bits by default). Every request input is captured on the rising clock edge. A static strap chooses the read latency. In flow-through mode the read word appears after the capturing edge. In pipelined mode it appears one edge later, after an output register. Writes are posted from the captured request and land in the array on the following edge. A write can therefore be read back by the very next request.

The port responds only when its active-low select is low and its active-high select is high. An active-low lane-enable vector picks which lanes a read drives or a write updates. Tri-state drive is modelled by a per-lane drive qualifier. A lane whose qualifier is low counts as high-impedance and carries zeros. An output-enable input gates the drive without a clock. A sleep input puts the port into a low-activity state over a fixed number of cycles and brings it back over a fixed number of cycles. While the port sleeps, requests are ignored and nothing is driven.

The request interface is a fixed-latency synchronous memory protocol. It has no valid/ready handshake and no back-pressure. Each clock accepts at most one request and never stalls.

Top module: `lane_sram_port`

## Requirements
- R1: Lane n of `wdata`/`rdata` occupies bits 9n to 9n+8, and `lane_drv[n]` qualifies it. `lane_drv[n]` = 1 means the lane is driven. Any `rdata` bit in a lane that is not driven reads 0.
- R2: A request is taken only when `sel_n` = 0 and `sel` = 1 at the capturing edge. Any other combination writes nothing and leads to no lane being driven.
- R3: `lane_en_n[n]` = 0 enables lane n. A write updates only the enabled lanes, and the other lanes keep their stored value. A read drives only the enabled lanes. Every one of the 16 patterns is legal.
- R4: `we_n` = 0 makes the request a write and `we_n` = 1 makes it a read. The cycle that shows a write's result drives no lane.
- R5: `oe_n` = 1 forces every `lane_drv` bit to 0 at once, without a clock edge. Returning `oe_n` to 0 restores the drive of the current read.
- R6: With `pipe_mode` = 0 (flow-through), a read captured at edge k drives its data from edge k until edge k+1.
- R7: With `pipe_mode` = 1 (pipelined), a read captured at edge k drives nothing between edges k and k+1. It drives its data from edge k+1 until edge k+2.
- R8: In pipelined mode the select and lane-enable effect passes through two register stages. A deselect captured at edge k removes the drive only after edge k+1.
- R9: Once `sleep` has been 1 at two consecutive edges, the port sleeps after the second of them. Requests captured at those two edges are still served. While the port sleeps, `lane_drv` is 0 and requests are ignored, writes included.
- R10: Once `sleep` has been 0 at three consecutive sleeping edges, the port wakes after the third. Requests at those three edges are ignored. The first request taken is the one at the next edge.
- R11: After reset `lane_drv` is 0 and `rdata` is 0 until a read is taken.
- R12: A read issued on the edge right after a write to the same address returns the newly written lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| pipe_mode | input | 1 | Static strap: 1 pipelined, 0 flow-through |
| sel_n | input | 1 | Active-low select |
| sel | input | 1 | Active-high select |
| we_n | input | 1 | 0 write, 1 read |
| lane_en_n | input | 4 | Active-low lane enables |
| addr | input | 6 | Word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Sleep request |
| rdata | output | 36 | Read data, zero in undriven lanes |
| lane_drv | output | 4 | Per-lane drive qualifier (0 = high-impedance) |

## Verification
The bench runs every lane-enable pattern in both latency modes. It reads each word back with all lanes enabled, which exposes a write mask that clobbers neighbouring lanes or a read that drives disabled lanes. It samples pipelined reads one cycle early, where the outputs must still be quiet, and it times a deselect to catch a single-stage enable path. A design without double buffering would drop the drive one cycle too soon. For sleep, it counts the edges on entry and exit and issues writes in the cycles that must be ignored. A counter that is off by one would either serve or lose one of those requests. Toggling `oe_n` between edges shows that the drive is gated without a register.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;
  localparam int DEF_LANES  = 4;
  localparam int DEF_LANE_W = 9;
  localparam int DEF_AW     = 6;

  typedef enum logic {
    ST_AWAKE  = 1'b0,
    ST_ASLEEP = 1'b1
  } doze_e;
endpackage

// File: rtl/lane_doze_ctl.sv
module lane_doze_ctl #(
  parameter int ENTER = 2,
  parameter int EXIT  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  output logic asleep
);
  import lane_sram_pkg::*;

  localparam int MAXC = (ENTER > EXIT) ? ENTER : EXIT;
  localparam int CW   = $clog2(MAXC + 1);

  doze_e         state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;
  logic          want;

  assign asleep = (state == ST_ASLEEP);
  assign want   = sleep;

  always_comb begin
    lim_m1 = asleep ? CW'(EXIT - 1) : CW'(ENTER - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_AWAKE;
      cnt   <= '0;
    end else if (want == asleep) begin
      cnt <= '0;
    end else if (cnt == lim_m1) begin
      state <= asleep ? ST_AWAKE : ST_ASLEEP;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lane_req_stage.sv
module lane_req_stage #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int AW     = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic                    sel_n,
  input  logic                    sel,
  input  logic                    we_n,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES-1:0]        wr_lanes,
  output logic [LANES-1:0]        rd_lanes,
  output logic [AW-1:0]           q_addr,
  output logic [LANES*LANE_W-1:0] q_wdata
);
  logic hit;
  assign hit = accept && !sel_n && sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_lanes <= '0;
      rd_lanes <= '0;
      q_addr   <= '0;
      q_wdata  <= '0;
    end else begin
      wr_lanes <= (hit && !we_n) ? ~lane_en_n : '0;
      rd_lanes <= (hit &&  we_n) ? ~lane_en_n : '0;
      q_addr   <= addr;
      q_wdata  <= wdata;
    end
  end
endmodule

// File: rtl/lane_mem_array.sv
module lane_mem_array #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int AW     = 6
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_lanes,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lanes[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = cells[addr];
  end
endmodule

// File: rtl/lane_out_stage.sv
module lane_out_stage #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pipe_mode,
  input  logic                    asleep,
  input  logic                    oe_n,
  input  logic [LANES-1:0]        rd_lanes,
  input  logic [LANES*LANE_W-1:0] mem_data,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        lane_drv
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic              p_en;
    logic [LANE_W-1:0] p_dat;
    logic              pick_en;
    logic [LANE_W-1:0] pick_dat;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        p_en  <= 1'b0;
        p_dat <= '0;
      end else begin
        p_en  <= rd_lanes[g] && !asleep;
        p_dat <= mem_data[g*LANE_W +: LANE_W];
      end
    end

    assign pick_en  = pipe_mode ? p_en  : rd_lanes[g];
    assign pick_dat = pipe_mode ? p_dat : mem_data[g*LANE_W +: LANE_W];
    assign lane_drv[g] = pick_en && !oe_n && !asleep;
    assign rdata[g*LANE_W +: LANE_W] = lane_drv[g] ? pick_dat : '0;
  end
endmodule

// File: rtl/lane_sram_port.sv
module lane_sram_port #(
  parameter int LANES     = lane_sram_pkg::DEF_LANES,
  parameter int LANE_W    = lane_sram_pkg::DEF_LANE_W,
  parameter int AW        = lane_sram_pkg::DEF_AW,
  parameter int SLEEP_IN  = 2,
  parameter int SLEEP_OUT = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pipe_mode,
  input  logic                    sel_n,
  input  logic                    sel,
  input  logic                    we_n,
  input  logic [LANES-1:0]        lane_en_n,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    oe_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        lane_drv
);
  localparam int DW = LANES * LANE_W;

  logic             asleep;
  logic [LANES-1:0] wr_lanes;
  logic [LANES-1:0] rd_lanes;
  logic [AW-1:0]    q_addr;
  logic [DW-1:0]    q_wdata;
  logic [DW-1:0]    mem_data;

  lane_doze_ctl #(.ENTER(SLEEP_IN), .EXIT(SLEEP_OUT)) u_doze (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .asleep(asleep)
  );

  lane_req_stage #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_req (
    .clk(clk), .rst_n(rst_n), .accept(!asleep),
    .sel_n(sel_n), .sel(sel), .we_n(we_n), .lane_en_n(lane_en_n),
    .addr(addr), .wdata(wdata),
    .wr_lanes(wr_lanes), .rd_lanes(rd_lanes),
    .q_addr(q_addr), .q_wdata(q_wdata)
  );

  lane_mem_array #(.LANES(LANES), .LANE_W(LANE_W), .AW(AW)) u_mem (
    .clk(clk), .wr_lanes(wr_lanes), .addr(q_addr),
    .wdata(q_wdata), .rdata(mem_data)
  );

  lane_out_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_out (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .asleep(asleep),
    .oe_n(oe_n), .rd_lanes(rd_lanes), .mem_data(mem_data),
    .rdata(rdata), .lane_drv(lane_drv)
  );
endmodule

// File: rtl/lane_sram_port_chk.sv
module lane_sram_port_chk #(
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pipe_mode,
  input logic                    sel_n,
  input logic                    sel,
  input logic                    we_n,
  input logic                    oe_n,
  input logic                    sleep,
  input logic                    asleep,
  input logic [LANES*LANE_W-1:0] rdata,
  input logic [LANES-1:0]        lane_drv
);
  logic [LANES*LANE_W-1:0] lane_bits;
  always_comb begin
    for (int i = 0; i < LANES; i++)
      lane_bits[i*LANE_W +: LANE_W] = {LANE_W{lane_drv[i]}};
  end

  assert_rdata_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~lane_bits) == '0);

  assert_oe_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (lane_drv == '0));

  assert_flow_desel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && (sel_n || !sel)) |=> (lane_drv == '0));

  assert_flow_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_mode && !asleep && !sel_n && sel && !we_n) |=> (lane_drv == '0));

  assert_pipe_desel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pipe_mode && (sel_n || !sel)) |=> ##1 (lane_drv == '0));

  assert_doze_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> (lane_drv == '0));

  assert_doze_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> ($past(sleep) && $past(sleep, 2)));

  assert_doze_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> (!$past(sleep) && !$past(sleep, 2) && !$past(sleep, 3)));
endmodule

bind lane_sram_port lane_sram_port_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .sel_n(sel_n), .sel(sel),
  .we_n(we_n), .oe_n(oe_n), .sleep(sleep), .asleep(asleep),
  .rdata(rdata), .lane_drv(lane_drv)
);

// File: tb/lane_sram_port_tb.sv
module lane_sram_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pipe_mode = 1'b0;
  logic        sel_n = 1'b1;
  logic        sel = 1'b0;
  logic        we_n = 1'b1;
  logic [3:0]  lane_en_n = 4'hF;
  logic [5:0]  addr = '0;
  logic [35:0] wdata = '0;
  logic        oe_n = 1'b0;
  logic        sleep = 1'b0;
  logic [35:0] rdata;
  logic [3:0]  lane_drv;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [35:0] model [64];

  always #2 clk = ~clk;

  lane_sram_port u_dut (
    .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode), .sel_n(sel_n), .sel(sel),
    .we_n(we_n), .lane_en_n(lane_en_n), .addr(addr), .wdata(wdata),
    .oe_n(oe_n), .sleep(sleep), .rdata(rdata), .lane_drv(lane_drv)
  );

  typedef struct packed {
    logic        pm;
    logic [3:0]  wbe;
    logic [3:0]  rbe;
    logic [5:0]  a;
    logic [35:0] d;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b0, 4'h0, 4'h0, 6'd1,  36'hF_EDCB_A987},
    '{1'b0, 4'hE, 4'h0, 6'd2,  36'h1_1111_1111},
    '{1'b0, 4'h7, 4'h8, 6'd3,  36'hA_AAAA_AAAA},
    '{1'b0, 4'hA, 4'h5, 6'd4,  36'h5_5555_5555},
    '{1'b0, 4'h0, 4'hF, 6'd5,  36'h0_0000_01FF},
    '{1'b0, 4'h3, 4'hC, 6'd6,  36'h3_FE00_7FC0},
    '{1'b1, 4'h0, 4'h0, 6'd7,  36'h9_8765_4321},
    '{1'b1, 4'hD, 4'h2, 6'd8,  36'h2_2222_2222},
    '{1'b1, 4'h9, 4'h6, 6'd9,  36'hC_3C3C_3C3C},
    '{1'b1, 4'h6, 4'h9, 6'd10, 36'h7_0F0F_0F0F},
    '{1'b1, 4'hB, 4'h0, 6'd11, 36'hE_0000_0000},
    '{1'b1, 4'h0, 4'hF, 6'd12, 36'h1_2345_6789}
  };

  function automatic logic [35:0] mask_of(input logic [3:0] en_n);
    logic [35:0] m;
    for (int i = 0; i < 4; i++) m[i*9 +: 9] = {9{~en_n[i]}};
    return m;
  endfunction

  task automatic chk(input string tag, input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic req(input logic s_n, input logic s, input logic w_n,
                     input logic [3:0] be, input logic [5:0] a, input logic [35:0] d);
    @(negedge clk);
    sel_n = s_n; sel = s; we_n = w_n; lane_en_n = be; addr = a; wdata = d;
  endtask

  task automatic idle_now();
    sel_n = 1'b1; sel = 1'b0; we_n = 1'b1; lane_en_n = 4'hF;
  endtask

  task automatic do_write(input logic [5:0] a, input logic [3:0] be, input logic [35:0] d);
    req(1'b0, 1'b1, 1'b0, be, a, d);
    model[a] = (model[a] & ~mask_of(be)) | (d & mask_of(be));
  endtask

  // R6 / R7: sample one cycle after capture, and in pipelined mode one more
  task automatic do_read(input logic [5:0] a, input logic [3:0] be, input string tag);
    req(1'b0, 1'b1, 1'b1, be, a, '0);
    @(negedge clk);
    if (pipe_mode) begin
      chk({tag, " R7 early quiet"}, {32'd0, lane_drv}, 36'd0);
      idle_now();
      @(negedge clk);
    end else begin
      idle_now();
    end
    chk({tag, " R3 drive"}, {32'd0, lane_drv}, {32'd0, ~be});
    chk({tag, " R1 data"}, rdata, model[a] & mask_of(be));
  endtask

  task automatic set_mode(input logic m);
    repeat (2) begin @(negedge clk); idle_now(); end
    pipe_mode = m;
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R6 got=hang expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: quiet after reset
    chk("R11 drive after reset", {32'd0, lane_drv}, 36'd0);
    chk("R11 data after reset", rdata, 36'd0);

    // fill the array with known words
    for (int a = 0; a < 64; a++) do_write(6'(a), 4'h0, {a[8:0], ~a[8:0], a[8:0] ^ 9'h155, 9'(a * 7)});

    // table walk
    for (int i = 0; i < 12; i++) begin
      if (pipe_mode != VECS[i].pm) set_mode(VECS[i].pm);
      do_write(VECS[i].a, VECS[i].wbe, VECS[i].d);
      do_read(VECS[i].a, VECS[i].rbe, "R3 table");
    end

    // every lane pattern in both modes
    for (int m = 0; m < 2; m++) begin
      set_mode(m[0]);
      for (int p = 0; p < 16; p++) begin
        do_write(6'(40 + p), 4'(p), 36'h1_3579_BDF0 ^ {4{5'(p), 4'(m)}});
        do_read(6'(40 + p), 4'(p), "R3 pattern");
        do_read(6'(40 + p), 4'h0, "R3 keep lanes");
      end
    end

    // R12: back-to-back write then read, flow-through
    set_mode(1'b0);
    do_write(6'd20, 4'h0, 36'hD_EAD0_BEEF);
    do_read(6'd20, 4'h0, "R12 back-to-back");

    // R4: the cycle showing a write drives nothing
    do_write(6'd21, 4'h0, 36'h0_1234_5678);
    @(negedge clk);
    chk("R4 write quiet", {32'd0, lane_drv}, 36'd0);
    idle_now();

    // R2: both deselect forms ignore writes and reads
    req(1'b1, 1'b1, 1'b0, 4'h0, 6'd22, 36'hF_FFFF_FFFF);
    req(1'b0, 1'b0, 1'b0, 4'h0, 6'd22, 36'hF_FFFF_FFFF);
    req(1'b0, 1'b0, 1'b1, 4'h0, 6'd22, '0);
    @(negedge clk);
    chk("R2 deselected read quiet", {32'd0, lane_drv}, 36'd0);
    idle_now();
    do_read(6'd22, 4'h0, "R2 deselected write ignored");

    // R5: output enable gates without a clock
    req(1'b0, 1'b1, 1'b1, 4'h0, 6'd20, '0);
    @(negedge clk);
    oe_n = 1'b1; #1;
    chk("R5 oe high drive", {32'd0, lane_drv}, 36'd0);
    chk("R5 oe high data", rdata, 36'd0);
    oe_n = 1'b0; #1;
    chk("R5 oe low drive", {32'd0, lane_drv}, 36'hF);
    chk("R5 oe low data", rdata, model[20]);
    idle_now();

    // R8: pipelined deselect needs two edges
    set_mode(1'b1);
    req(1'b0, 1'b1, 1'b1, 4'h5, 6'd9, '0);
    @(negedge clk);
    chk("R7 pipe early", {32'd0, lane_drv}, 36'd0);
    sel_n = 1'b1;
    @(negedge clk);
    chk("R8 still driven", {32'd0, lane_drv}, 36'hA);
    chk("R8 still data", rdata, model[9] & mask_of(4'h5));
    sel_n = 1'b0; sel = 1'b0;
    @(negedge clk);
    chk("R8 released", {32'd0, lane_drv}, 36'd0);
    idle_now();

    // R9 / R10: sleep entry and exit, flow-through
    set_mode(1'b0);
    req(1'b0, 1'b1, 1'b1, 4'h0, 6'd30, '0);
    sleep = 1'b1;
    req(1'b0, 1'b1, 1'b1, 4'h0, 6'd31, '0);
    chk("R9 served in entry", {32'd0, lane_drv}, 36'hF);
    chk("R9 served data", rdata, model[30]);
    req(1'b0, 1'b1, 1'b0, 4'h0, 6'd32, 36'hB_ADBA_DBAD);
    chk("R9 asleep quiet", {32'd0, lane_drv}, 36'd0);
    req(1'b1, 1'b0, 1'b1, 4'hF, 6'd0, '0);
    repeat (3) @(negedge clk);
    sleep = 1'b0;
    sel_n = 1'b0; sel = 1'b1; we_n = 1'b0; lane_en_n = 4'h0; addr = 6'd33; wdata = 36'hC_0FFE_E000;
    req(1'b0, 1'b1, 1'b1, 4'h0, 6'd32, '0);
    req(1'b0, 1'b1, 1'b0, 4'h0, 6'd32, 36'h6_6666_6666);
    req(1'b0, 1'b1, 1'b1, 4'h0, 6'd32, '0);
    chk("R10 still quiet on exit", {32'd0, lane_drv}, 36'd0);
    @(negedge clk);
    idle_now();
    chk("R10 first served drive", {32'd0, lane_drv}, 36'hF);
    chk("R10 writes ignored in sleep", rdata, model[32]);
    do_read(6'd33, 4'h0, "R10 exit write ignored");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule